// File: doc/BRIEF.md
# Ethernet Receive Frame Error Classifier

This block sits at the tail of an Ethernet receive path and gives every incoming frame its final status. During a frame the receiver may report a receive-FIFO overrun (the newest byte overwrote the previous one, so that byte and the frame status are lost) or that no receive buffer was free. At the end of the frame the receiver supplies the number of residual bits left past the last whole octet (0 to 7) and the result of a CRC check taken at the last octet boundary. The CRC check is always performed and cannot be turned off. Software may still choose to ignore the result.

From these inputs the block picks one outcome per frame. The outcomes are overrun, busy (dropped for lack of a buffer), non-octet-aligned error, CRC error or good. It then drives descriptor status bits, event flags, a buffer-close strobe and a hunt-mode request back to the receiver. It also keeps three saturating statistics counters: discarded frames, CRC errors and alignment errors.

Top module: `rx_frame_classifier`

## Requirements
- R1: After reset every output strobe, flag and descriptor bit is 0 and all three counters read 0.
- R2: A frame during which `fifoOverrun` was seen gives, in the cycle after `frameEnd`: `bufClose`=1, `descOverrun`=1, `evRxFrame`=1, `huntReq`=1 and `evBusy`=0. `discardCnt` increments by one.
- R3: A frame during which `noBuffer` was seen, without an overrun, gives in the cycle after `frameEnd`: `evBusy`=1, `huntReq`=1, `bufClose`=0 and `evRxFrame`=0. `discardCnt` increments by one.
- R4: When both overrun and no-buffer are seen in one frame, overrun wins: the result is the R2 outcome with `evBusy`=0, and `discardCnt` increments exactly once.
- R5: A frame with no overrun or no-buffer indication, `residBits`≠0 and `crcBad`=1 is a non-octet-aligned error. It gives `descAlignErr`=1, `evRxFrame`=1, `bufClose`=1 and `huntReq`=1. `alignErrCnt` increments and `crcErrCnt` is unchanged.
- R6: A frame with no overrun or no-buffer indication and `crcBad`=0 is good, for any `residBits` value 0 to 7. It gives `bufClose`=1 and `evRxFrame`=1, all descriptor error bits 0, `huntReq`=0, and no counter changes.
- R7: A frame with no overrun or no-buffer indication, `residBits`=0 and `crcBad`=1 is a CRC error. It gives `descCrcErr`=1, `evRxFrame`=1, `bufClose`=1 and `huntReq`=1. `crcErrCnt` increments.
- R8: Overrun and no-buffer indications count toward the current frame when they arrive in any cycle from the one after the previous `frameEnd` up to and including the current `frameEnd` cycle. They are forgotten once that frame is classified.
- R9: The counters are `CNT_W` bits wide (default 16) and hold at 2^CNT_W−1 instead of wrapping.
- R10: Every output strobe, flag and descriptor bit is a single-cycle pulse, issued only in the cycle after a `frameEnd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameEnd | input | 1 | One-cycle strobe marking the end of a received frame |
| residBits | input | RESID_W | Residual bits past the last whole octet, valid with `frameEnd` |
| crcBad | input | 1 | CRC mismatch at the last octet boundary, valid with `frameEnd` |
| fifoOverrun | input | 1 | Receive FIFO overran in this cycle |
| noBuffer | input | 1 | No free receive buffer for the current frame |
| descOverrun | output | 1 | Descriptor overrun bit |
| descCrcErr | output | 1 | Descriptor CRC-error bit |
| descAlignErr | output | 1 | Descriptor non-octet-aligned error bit |
| evRxFrame | output | 1 | Frame-received event |
| evBusy | output | 1 | Busy (frame dropped, no buffer) event |
| bufClose | output | 1 | Close the current receive buffer |
| huntReq | output | 1 | Request the receiver to enter hunt mode |
| discardCnt | output | CNT_W | Discarded-frame counter |
| crcErrCnt | output | CNT_W | CRC-error counter |
| alignErrCnt | output | CNT_W | Alignment-error counter |

## Verification
A stale overrun or no-buffer memory would leak into the next frame. That frame would then show a wrong descriptor bit and a spurious discard increment in the cycle after its `frameEnd`. The bench therefore places a clean frame right after each faulty one, so the leak is caught within one frame. A wrong priority or a wrong residual-bit test shows up in the same cycle as the flag pattern and counter deltas, which the bench compares for every combination of indications, residual count and CRC result. A counter that wraps instead of saturating shows up as a sudden drop to a small value, which the narrowed bench counters reach within the same sweep.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  typedef enum logic [2:0] {
    CLS_GOOD    = 3'd0,
    CLS_ALIGN   = 3'd1,
    CLS_CRC     = 3'd2,
    CLS_BUSY    = 3'd3,
    CLS_OVERRUN = 3'd4
  } frameClass_e;

  localparam int NUM_CNT  = 3;
  localparam int IDX_DISC = 0;
  localparam int IDX_CRC  = 1;
  localparam int IDX_ALGN = 2;

  typedef struct packed {
    logic incAlign;
    logic incCrc;
    logic incDiscard;
  } ctrlStrobes_t;

endpackage

// File: rtl/rxc_sat_counter.sv
module rxc_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN)                         cnt <= '0;
    else if (inc && (cnt != CNT_MAX))  cnt <= cnt + 1'b1;
  end

  // R9: a full counter never wraps
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R9: an increment below the limit advances by exactly one
  assert_inc_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inc && cnt != CNT_MAX && $past(rstN)) |=> (cnt == $past(cnt) + 1'b1));

  // R9: without an increment the count is stable
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!inc && $past(rstN)) |=> $stable(cnt));
endmodule

// File: rtl/rxc_counters.sv
module rxc_counters
  import rxc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  output logic [NUM_CNT-1:0][CNT_W-1:0] counts
);
  logic [NUM_CNT-1:0] incVec;

  always_comb begin
    incVec           = '0;
    incVec[IDX_DISC] = strobes.incDiscard;
    incVec[IDX_CRC]  = strobes.incCrc;
    incVec[IDX_ALGN] = strobes.incAlign;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    rxc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .inc  (incVec[g]),
      .cnt  (counts[g])
    );
  end

  // R4 / R5 / R7: a frame bumps at most one counter
  assert_one_counter_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(incVec));
endmodule

// File: rtl/rxc_ctrl.sv
module rxc_ctrl
  import rxc_pkg::*;
#(
  parameter int RESID_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameEnd,
  input  logic [RESID_W-1:0] residBits,
  input  logic               crcBad,
  input  logic               fifoOverrun,
  input  logic               noBuffer,
  output logic               descOverrun,
  output logic               descCrcErr,
  output logic               descAlignErr,
  output logic               evRxFrame,
  output logic               evBusy,
  output logic               bufClose,
  output logic               huntReq,
  output ctrlStrobes_t       strobes
);
  logic        ovrSeen, nobufSeen;
  logic        ovrNow, nobufNow;
  frameClass_e frameClass;

  // R8: remember indications until the frame is classified
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrSeen   <= 1'b0;
      nobufSeen <= 1'b0;
    end else if (frameEnd) begin
      ovrSeen   <= 1'b0;
      nobufSeen <= 1'b0;
    end else begin
      ovrSeen   <= ovrSeen | fifoOverrun;
      nobufSeen <= nobufSeen | noBuffer;
    end
  end

  assign ovrNow   = ovrSeen | fifoOverrun;
  assign nobufNow = nobufSeen | noBuffer;

  // Priority: overrun, busy, alignment, CRC, good
  always_comb begin
    if (ovrNow)                           frameClass = CLS_OVERRUN;
    else if (nobufNow)                    frameClass = CLS_BUSY;
    else if (crcBad && residBits != '0)   frameClass = CLS_ALIGN;
    else if (crcBad)                      frameClass = CLS_CRC;
    else                                  frameClass = CLS_GOOD;
  end

  always_comb begin
    strobes            = '0;
    strobes.incDiscard = frameEnd && (frameClass == CLS_OVERRUN || frameClass == CLS_BUSY);
    strobes.incCrc     = frameEnd && (frameClass == CLS_CRC);
    strobes.incAlign   = frameEnd && (frameClass == CLS_ALIGN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descOverrun  <= 1'b0;
      descCrcErr   <= 1'b0;
      descAlignErr <= 1'b0;
      evRxFrame    <= 1'b0;
      evBusy       <= 1'b0;
      bufClose     <= 1'b0;
      huntReq      <= 1'b0;
    end else begin
      descOverrun  <= frameEnd && frameClass == CLS_OVERRUN;
      descCrcErr   <= frameEnd && frameClass == CLS_CRC;
      descAlignErr <= frameEnd && frameClass == CLS_ALIGN;
      evRxFrame    <= frameEnd && frameClass != CLS_BUSY;
      evBusy       <= frameEnd && frameClass == CLS_BUSY;
      bufClose     <= frameEnd && frameClass != CLS_BUSY;
      huntReq      <= frameEnd && frameClass != CLS_GOOD;
    end
  end

  // R10: hunt request only follows a frame end
  assert_hunt_after_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    huntReq |-> $past(frameEnd));

  // R10: buffer close only follows a frame end
  assert_close_after_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    (bufClose || evBusy) |-> $past(frameEnd));

  // R4: at most one descriptor error bit per frame
  assert_one_desc_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({descOverrun, descCrcErr, descAlignErr}));

  // R3: a busy frame never closes a buffer
  assert_busy_no_close_R3: assert property (@(posedge clk) disable iff (!rstN)
    evBusy |-> (!bufClose && !evRxFrame && huntReq));

  // R2: an overrun frame always asks for hunt
  assert_overrun_hunt_R2: assert property (@(posedge clk) disable iff (!rstN)
    descOverrun |-> (huntReq && bufClose && !evBusy));
endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
  import rxc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RESID_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameEnd,
  input  logic [RESID_W-1:0] residBits,
  input  logic               crcBad,
  input  logic               fifoOverrun,
  input  logic               noBuffer,
  output logic               descOverrun,
  output logic               descCrcErr,
  output logic               descAlignErr,
  output logic               evRxFrame,
  output logic               evBusy,
  output logic               bufClose,
  output logic               huntReq,
  output logic [CNT_W-1:0]   discardCnt,
  output logic [CNT_W-1:0]   crcErrCnt,
  output logic [CNT_W-1:0]   alignErrCnt
);
  ctrlStrobes_t                  strobes;
  logic [NUM_CNT-1:0][CNT_W-1:0] counts;

  rxc_ctrl #(.RESID_W(RESID_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameEnd     (frameEnd),
    .residBits    (residBits),
    .crcBad       (crcBad),
    .fifoOverrun  (fifoOverrun),
    .noBuffer     (noBuffer),
    .descOverrun  (descOverrun),
    .descCrcErr   (descCrcErr),
    .descAlignErr (descAlignErr),
    .evRxFrame    (evRxFrame),
    .evBusy       (evBusy),
    .bufClose     (bufClose),
    .huntReq      (huntReq),
    .strobes      (strobes)
  );

  rxc_counters #(.CNT_W(CNT_W)) u_counters (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .counts  (counts)
  );

  assign discardCnt  = counts[IDX_DISC];
  assign crcErrCnt   = counts[IDX_CRC];
  assign alignErrCnt = counts[IDX_ALGN];
endmodule

// File: tb/rx_frame_classifier_tb.sv
module rx_frame_classifier_tb;
  localparam int CW  = 5;
  localparam int RW  = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN;
  logic frameEnd, crcBad, fifoOverrun, noBuffer;
  logic [RW-1:0] residBits;
  logic descOverrun, descCrcErr, descAlignErr, evRxFrame, evBusy, bufClose, huntReq;
  logic [CW-1:0] discardCnt, crcErrCnt, alignErrCnt;

  int nChecks = 0;
  int nFails  = 0;
  int expDisc = 0, expCrc = 0, expAlign = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_frame_classifier #(.CNT_W(CW), .RESID_W(RW)) u_dut (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .residBits(residBits),
    .crcBad(crcBad), .fifoOverrun(fifoOverrun), .noBuffer(noBuffer),
    .descOverrun(descOverrun), .descCrcErr(descCrcErr), .descAlignErr(descAlignErr),
    .evRxFrame(evRxFrame), .evBusy(evBusy), .bufClose(bufClose), .huntReq(huntReq),
    .discardCnt(discardCnt), .crcErrCnt(crcErrCnt), .alignErrCnt(alignErrCnt)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v < MAXC) ? v + 1 : MAXC;
  endfunction

  // flags order: {descOverrun, descCrcErr, descAlignErr, evRxFrame, evBusy, bufClose, huntReq}
  task automatic runFrame(bit ovr, bit nob, int res, bit bad, bit late);
    logic [6:0] expFlags;
    string tag;
    @(negedge clk);
    if (!late) begin fifoOverrun = ovr; noBuffer = nob; end
    @(negedge clk);
    fifoOverrun = late ? ovr : 1'b0;
    noBuffer    = late ? nob : 1'b0;
    frameEnd = 1'b1; residBits = RW'(res); crcBad = bad;
    if (ovr) begin
      expFlags = 7'b1001011; expDisc = sat(expDisc);
      tag = nob ? "R4" : "R2";
    end else if (nob) begin
      expFlags = 7'b0000101; expDisc = sat(expDisc); tag = "R3";
    end else if (bad && res != 0) begin
      expFlags = 7'b0011011; expAlign = sat(expAlign); tag = "R5";
    end else if (bad) begin
      expFlags = 7'b0101011; expCrc = sat(expCrc); tag = "R7";
    end else begin
      expFlags = 7'b0001010; tag = "R6";
    end
    if (late) tag = {tag, "/R8"};
    @(negedge clk);
    frameEnd = 1'b0; fifoOverrun = 1'b0; noBuffer = 1'b0; crcBad = 1'b0; residBits = '0;
    check({tag, " flags"}, 64'({descOverrun, descCrcErr, descAlignErr, evRxFrame, evBusy, bufClose, huntReq}),
          64'(expFlags));
    check({tag, "/R9 counters"}, 64'({discardCnt, crcErrCnt, alignErrCnt}),
          64'({CW'(expDisc), CW'(expCrc), CW'(expAlign)}));
    @(negedge clk);
    check("R10 pulse cleared", 64'({descOverrun, descCrcErr, descAlignErr, evRxFrame, evBusy, bufClose, huntReq}),
          64'(0));
  endtask

  initial begin
    rstN = 1'b0; frameEnd = 1'b0; crcBad = 1'b0; fifoOverrun = 1'b0; noBuffer = 1'b0; residBits = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset flags", 64'({descOverrun, descCrcErr, descAlignErr, evRxFrame, evBusy, bufClose, huntReq}), 64'(0));
    check("R1 reset counters", 64'({discardCnt, crcErrCnt, alignErrCnt}), 64'(0));
    for (int late = 0; late < 2; late++)
      for (int res = 0; res < 8; res++)
        for (int bad = 0; bad < 2; bad++)
          for (int kind = 0; kind < 4; kind++) begin
            runFrame(kind[0], kind[1], res, bad[0], late[0]);
            runFrame(1'b0, 1'b0, 0, 1'b0, 1'b0); // clean frame exposes stale state (R8)
          end
    // R9: drive the CRC and alignment counters to their limit
    for (int i = 0; i < MAXC + 3; i++) begin
      runFrame(1'b0, 1'b0, 0, 1'b1, 1'b0);
      runFrame(1'b0, 1'b0, 5, 1'b1, 1'b0);
    end
    check("R9 discard saturated", 64'(discardCnt), 64'(MAXC));
    check("R9 crc saturated", 64'(crcErrCnt), 64'(MAXC));
    check("R9 align saturated", 64'(alignErrCnt), 64'(MAXC));
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule